// File: doc/BRIEF.md
# Chroma nibble demultiplexer

This block rebuilds full-width U and V colour-difference samples from a narrow chroma bus. The sender shares one 4-bit bus between both components. Each group of four main-clock periods carries one U/V pair as four nibbles, and the U and V halves are interleaved. There is no separate chroma clock and no frame strobe. A two-bit phase counter, clocked by the main pixel clock, tracks which nibble is on the bus.

Alignment comes from the bus itself. During vertical blanking, the sender drives a pulse on bit 0 of the chroma bus. While the blanking-window qualifier is high, a rising edge on that bit realigns the counter. Between such events the counter keeps its cadence on its own.

The nibble path serves only the legacy 4:1:1 input mode. A 3-bit mode code selects it. In every other mode, the block freezes its outputs.

Top module: `chroma_nibble_demux`

## Requirements
- R1: While reset is high at a clock edge, and afterwards until the first completed pair, `u_o` and `v_o` read 0x00, `valid_o` is low and the block counts as unsynchronised.
- R2: A sync event is a cycle in which `vblank_i` is 1, `chroma_i[0]` is 1, and `chroma_i[0]` was 0 in the previous cycle. The nibble on the bus in the clock after a sync event is taken as the U high nibble.
- R3: A rising edge on `chroma_i[0]` while `vblank_i` is 0 is not a sync event, and it does not change the phase of the nibble cadence.
- R4: After a sync, the nibbles arrive in a fixed order that repeats: U[7:4], then V[3:0], then V[7:4], then U[3:0]. The block outputs U = {U high, U low} and V = {V high, V low}.
- R5: The phase counter advances by one every clock, modulo 4, with no further sync. Back-to-back groups are each assembled correctly.
- R6: `u_o` and `v_o` both update in the cycle after the U low nibble is captured. `valid_o` is high for exactly that one cycle.
- R7: Between valid pulses, `u_o` and `v_o` hold their last values.
- R8: Before the first sync event after reset, no pair is produced and `valid_o` stays low, whatever the bus carries.
- R9: Only mode code 3'b001 (legacy 4:1:1) produces pairs. Every other code, including 3'b000 (legacy 4:2:2), keeps `valid_o` low and holds `u_o` and `v_o`.
- R10: A sync cycle never carries data. If a sync event lands on the U low slot, that pair is dropped and the outputs hold. A sync event part-way through a group discards the partial group, and the next four nibbles form a fresh pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| chroma_i | input | 4 | Time-multiplexed U/V nibble bus; bit 0 carries the sync pulse in blanking |
| vblank_i | input | 1 | Sync-window qualifier, high during vertical blanking |
| mode_i | input | 3 | Input mode code; 3'b001 enables the nibble path |
| u_o | output | 8 | Assembled U sample |
| v_o | output | 8 | Assembled V sample |
| valid_o | output | 1 | One-cycle strobe marking a fresh U/V pair |

## Verification
Phase realignment and pair completion can fall in the same clock. This happens when a sync event lands exactly where the U low nibble is due. The bench provokes it by streaming three nibbles of a group and then raising the qualifier with a rising bit 0 in the fourth slot. It judges the result in two parts. First, that cycle must give no valid pulse and the outputs must not change. Second, the following four nibbles must still yield the exact pair expected from a fresh group.

// File: rtl/cdmx_pkg.sv
package cdmx_pkg;

    localparam int NIBBLE_W   = 4;
    localparam int MODE_W     = 3;
    localparam int PHASES     = 4;
    localparam int PHASE_W    = $clog2(PHASES);

    localparam logic [MODE_W-1:0] MODE_LEGACY_422 = 3'b000;
    localparam logic [MODE_W-1:0] MODE_LEGACY_411 = 3'b001;

    // bus slot order inside one group
    typedef enum logic [PHASE_W-1:0] {
        SLOT_U_HI = 2'd0,
        SLOT_V_LO = 2'd1,
        SLOT_V_HI = 2'd2,
        SLOT_U_LO = 2'd3
    } slot_e;

    function automatic slot_e slot_advance(input slot_e s);
        return slot_e'(s + 2'd1);
    endfunction

    function automatic logic mode_uses_nibbles(input logic [MODE_W-1:0] m);
        return m == MODE_LEGACY_411;
    endfunction

endpackage

// File: rtl/cdmx_sync_detect.sv
module cdmx_sync_detect (
    input  logic clk,
    input  logic rst,
    input  logic marker_i,
    input  logic window_i,
    output logic sync_o
);
    logic marker_prev_q;

    always_ff @(posedge clk) begin
        if (rst) marker_prev_q <= 1'b0;
        else     marker_prev_q <= marker_i;
    end

    assign sync_o = window_i && marker_i && !marker_prev_q;

endmodule

// File: rtl/cdmx_phase_ctr.sv
module cdmx_phase_ctr
    import cdmx_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  sync_i,
    output slot_e slot_o,
    output logic  locked_o
);
    slot_e slot_q;
    logic  locked_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q   <= SLOT_U_HI;
            locked_q <= 1'b0;
        end else if (sync_i) begin
            slot_q   <= SLOT_U_HI;
            locked_q <= 1'b1;
        end else begin
            slot_q   <= slot_advance(slot_q);
        end
    end

    assign slot_o   = slot_q;
    assign locked_o = locked_q;

    p_realign_r2: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> (slot_q == SLOT_U_HI) && locked_q);

    p_free_run_r5: assert property (@(posedge clk) disable iff (rst)
        !sync_i |=> slot_q == slot_e'($past(slot_q) + 2'd1));

    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> locked_q);

endmodule

// File: rtl/cdmx_assemble.sv
module cdmx_assemble
    import cdmx_pkg::*;
#(
    parameter int NIB_W    = NIBBLE_W,
    localparam int SAMP_W  = 2 * NIB_W
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] nib_i,
    input  slot_e            slot_i,
    input  logic             locked_i,
    input  logic             sync_i,
    input  logic             enable_i,
    output logic [SAMP_W-1:0] u_o,
    output logic [SAMP_W-1:0] v_o,
    output logic             valid_o
);
    logic [NIB_W-1:0]  u_hi_q, v_lo_q, v_hi_q;
    logic [SAMP_W-1:0] u_q, v_q;
    logic              valid_q;
    logic              take;

    assign take = locked_i && !sync_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            u_hi_q  <= '0;
            v_lo_q  <= '0;
            v_hi_q  <= '0;
            u_q     <= '0;
            v_q     <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (take) begin
                unique case (slot_i)
                    SLOT_U_HI: u_hi_q <= nib_i;
                    SLOT_V_LO: v_lo_q <= nib_i;
                    SLOT_V_HI: v_hi_q <= nib_i;
                    SLOT_U_LO: begin
                        if (enable_i) begin
                            u_q     <= {u_hi_q, nib_i};
                            v_q     <= {v_hi_q, v_lo_q};
                            valid_q <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign u_o     = u_q;
    assign v_o     = v_q;
    assign valid_o = valid_q;

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);

    p_hold_u_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(u_q) |-> valid_q || $past(rst));

    p_hold_v_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(v_q) |-> valid_q || $past(rst));

    p_need_lock_r8: assert property (@(posedge clk) disable iff (rst)
        !locked_i |=> !valid_q);

    p_sync_no_data_r10: assert property (@(posedge clk) disable iff (rst)
        sync_i |=> !valid_q);

endmodule

// File: rtl/chroma_nibble_demux.sv
module chroma_nibble_demux
    import cdmx_pkg::*;
#(
    parameter int NIB_W   = NIBBLE_W,
    parameter int MODE_BW = MODE_W
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NIB_W-1:0]     chroma_i,
    input  logic                 vblank_i,
    input  logic [MODE_BW-1:0]   mode_i,
    output logic [2*NIB_W-1:0]   u_o,
    output logic [2*NIB_W-1:0]   v_o,
    output logic                 valid_o
);
    logic  sync_hit;
    logic  locked;
    logic  path_en;
    slot_e slot;

    assign path_en = mode_uses_nibbles(MODE_W'(mode_i));

    cdmx_sync_detect u_sync (
        .clk      (clk),
        .rst      (rst),
        .marker_i (chroma_i[0]),
        .window_i (vblank_i),
        .sync_o   (sync_hit)
    );

    cdmx_phase_ctr u_phase (
        .clk      (clk),
        .rst      (rst),
        .sync_i   (sync_hit),
        .slot_o   (slot),
        .locked_o (locked)
    );

    cdmx_assemble #(.NIB_W(NIB_W)) u_asm (
        .clk      (clk),
        .rst      (rst),
        .nib_i    (chroma_i),
        .slot_i   (slot),
        .locked_i (locked),
        .sync_i   (sync_hit),
        .enable_i (path_en),
        .u_o      (u_o),
        .v_o      (v_o),
        .valid_o  (valid_o)
    );

    p_mode_gate_r9: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> $past(mode_i) == MODE_BW'(MODE_LEGACY_411));

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> !valid_o && (u_o == '0) && (v_o == '0));

endmodule

// File: tb/chroma_nibble_demux_tb.sv
module chroma_nibble_demux_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] chroma;
    logic       vblank;
    logic [2:0] mode;
    logic [7:0] u, v;
    logic       valid;

    int errors = 0;
    int checks = 0;
    logic [7:0] hold_u, hold_v;

    always #5 clk = ~clk;

    chroma_nibble_demux u_dut (
        .clk(clk), .rst(rst), .chroma_i(chroma), .vblank_i(vblank),
        .mode_i(mode), .u_o(u), .v_o(v), .valid_o(valid)
    );

    // {U, V} pairs streamed back to back after one sync
    localparam logic [15:0] VEC [6] = '{
        16'h3CA5, 16'hFF00, 16'h00FF, 16'h1234, 16'h8E71, 16'h5AC3
    };

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic step(input logic [3:0] n, input logic vb);
        chroma = n;
        vblank = vb;
        @(negedge clk);
    endtask

    task automatic do_sync();
        step(4'h0, 1'b1);
        step(4'h1, 1'b1);
    endtask

    task automatic send_pair(input logic [7:0] pu, input logic [7:0] pv,
                             input logic exp_valid, input string tag);
        step(pu[7:4], 1'b0); chk({tag, " mid valid"}, {7'b0, valid}, 8'h00);
        step(pv[3:0], 1'b0);
        step(pv[7:4], 1'b0); chk({tag, " mid valid"}, {7'b0, valid}, 8'h00);
        step(pu[3:0], 1'b0);
        chk({tag, " valid"}, {7'b0, valid}, {7'b0, exp_valid});
        if (exp_valid) begin
            chk({tag, " U"}, u, pu);
            chk({tag, " V"}, v, pv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        report();
    end

    initial begin
        rst = 1'b1; chroma = '0; vblank = 1'b0; mode = 3'b001;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk("R1 U", u, 8'h00); chk("R1 V", v, 8'h00);
        chk("R1 valid", {7'b0, valid}, 8'h00);
        rst = 1'b0;

        // R8 and R3: no sync yet; bit0 rising edges with the window low
        for (int i = 0; i < 12; i++) begin
            step(4'(i), 1'b0);
            chk("R8/R3 no valid unsynced", {7'b0, valid}, 8'h00);
        end
        chk("R8 U held zero", u, 8'h00);

        // R2 R4 R5 R6: one sync, then the table streamed back to back
        do_sync();
        for (int k = 0; k < 6; k++)
            send_pair(VEC[k][15:8], VEC[k][7:0], 1'b1, "R4/R5/R6 vec");

        // R7 hold between pulses
        step(4'h7, 1'b0);
        chk("R7 valid low", {7'b0, valid}, 8'h00);
        chk("R7 U held", u, 8'h5A); chk("R7 V held", v, 8'hC3);

        // R3: a bit0 rising edge with the window low must not shift phase
        do_sync();
        step(4'h6, 1'b0); step(4'h0, 1'b0); step(4'h1, 1'b0); step(4'h9, 1'b0);
        chk("R3 phase kept U", u, 8'h69); chk("R3 phase kept V", v, 8'h10);
        chk("R3 valid", {7'b0, valid}, 8'h01);

        // R10 collision: sync lands on the U low slot
        do_sync();
        step(4'hA, 1'b0); step(4'h5, 1'b0); step(4'h2, 1'b0);
        step(4'h1, 1'b1);
        chk("R10 collision valid", {7'b0, valid}, 8'h00);
        chk("R10 collision U held", u, 8'h69);
        chk("R10 collision V held", v, 8'h10);
        send_pair(8'hD7, 8'h4B, 1'b1, "R10 after collision");

        // R10 mid-group sync discards partial group
        step(4'hE, 1'b0); step(4'h2, 1'b0);
        do_sync();
        send_pair(8'h96, 8'h28, 1'b1, "R10 mid-group realign");

        // R9 mode gating
        mode = 3'b000;
        send_pair(8'h11, 8'h22, 1'b0, "R9 mode 000");
        chk("R9 U held", u, 8'h96); chk("R9 V held", v, 8'h28);
        mode = 3'b101;
        send_pair(8'h33, 8'h44, 1'b0, "R9 mode 101");
        chk("R9 V held 101", v, 8'h28);
        mode = 3'b001;
        send_pair(8'hC4, 8'h3B, 1'b1, "R9 mode 001 resumes");

        // R1/R8 reset mid-stream clears and unlocks
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        chk("R1 mid reset U", u, 8'h00); chk("R1 mid reset V", v, 8'h00);
        send_pair(8'h5E, 8'hA1, 1'b0, "R8 after reset");
        chk("R8 U zero", u, 8'h00);

        report();
    end

endmodule